// File: doc/BRIEF.md
# Variable Mark-Ratio Pseudo-Random Bit Source

This block emits one bit per clock from a maximal-length linear feedback shift register. A 3-bit select picks the register length, and with it the period 2^n-1, from seven standard lengths. An optional shaping stage lowers or raises the density of ones. It ANDs the current sequence bit with delayed copies of itself, taken 1 bit or 3 bits apart, and can invert the result. This gives quasi-random streams at 1/4, 1/8, 3/4 and 7/8 density, which stress the baseline wander and the decision threshold of a receiver under test. A single-cycle pulse marks the first bit of every period, so a scope or an error counter can lock to the pattern.

A small controller has two states. SEED means the register holds its all-ones start value and nothing has been emitted since it was loaded. RUN means at least one bit has been emitted since the last load. The transitions are: reset enters SEED; SEED to RUN (named ADVANCE) on a clock where the enable is high and the polynomial select is unchanged; RUN to SEED or SEED to SEED (named RELOAD) on any clock where the polynomial select differs from its registered copy; every other clock is HOLD, or STEP while running. The shaping stage is combinational on the register, so a new mark ratio or spacing shows on the very next output sample.

Top module: `prbs_mr_gen`

## Requirements
- R1: While reset is low, and on the first clock after reset, the register holds all ones: with ratio 1/2, bit_o is 1 and period_start_o is 0.
- R2: Polynomial select codes 0..6 give n = 7, 9, 11, 15, 20, 23, 31 with taps t = 6, 5, 9, 14, 3, 18, 28. The plain bit sequence follows a[k] = a[k-t] XOR a[k-n], and every bit before index 0 is 1. Code 7 behaves as code 0.
- R3: For n = 7, one period starts 0000001000001100001010 and holds 64 ones and 63 zeros, with longest runs of 6 zeros and 7 ones.
- R4: period_start_o is high exactly on the clocks where bit index k is a multiple of 2^n-1, so once per period, and on no other clock.
- R5: With enable low and the select unchanged, bit_o holds its value, period_start_o stays low, and the sequence resumes where it stopped.
- R6: A change of polynomial select reloads all ones on the next clock, whatever the enable. bit_o shows 1 with no pulse on that clock, and the new sequence then starts at index 0.
- R7: The low n bits of the register are never all zero.
- R8: Ratio select 0 = 1/2 (plain), 1 = 1/4 (a[k] AND a[k-d]), 2 = 1/8 (a[k] AND a[k-d] AND a[k-2d]), 3 = 3/4, 4 = 7/8; codes 5..7 act as 1/2. Spacing select 0 gives d = 1 and 1 gives d = 3. For n = 7, a period holds 32 ones at 1/4 and 16 ones at 1/8 with either spacing.
- R9: For n = 7, the 1/4 stream with d = 1 never contains 101, and the one with d = 3 does.
- R10: The 3/4 and 7/8 streams are the bitwise inverse of the 1/4 and 1/8 streams (95 and 111 ones per n = 7 period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance the sequence by one bit |
| poly_sel_i | input | 3 | Register length select |
| ratio_sel_i | input | 3 | Mark ratio select |
| spacing_i | input | 1 | 0: taps 1 bit apart, 1: taps 3 bits apart |
| bit_o | output | 1 | Serial pattern bit |
| period_start_o | output | 1 | High on the first bit of each period |

## Verification
The hardest situation to reach is the wrap of the period. The pulse must fire a second time exactly 2^n-1 bits after the first, and the shaped streams must stay consistent across the boundary where the delayed taps reach back into the previous period. The stimulus runs complete periods for n = 7, 9 and 11 with the enable held high. It compares every bit and pulse with a recurrence computed in the bench. It then sweeps all ten ratio and spacing pairs over a full n = 7 period. Reload is driven mid-run with the enable both high and low.

// File: rtl/prbs_mr_pkg.sv
package prbs_mr_pkg;

    localparam int MAX_LEN = 31;
    localparam int HIST_W  = 7;

    typedef enum logic [2:0] {
        MR_HALF         = 3'd0,
        MR_QUARTER      = 3'd1,
        MR_EIGHTH       = 3'd2,
        MR_THREE_QTR    = 3'd3,
        MR_SEVEN_EIGHTH = 3'd4
    } mark_ratio_t;

    typedef enum logic {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_t;

    function automatic int seq_len(input logic [2:0] sel);
        case (sel)
            3'd1:    return 9;
            3'd2:    return 11;
            3'd3:    return 15;
            3'd4:    return 20;
            3'd5:    return 23;
            3'd6:    return 31;
            default: return 7;
        endcase
    endfunction

    function automatic int seq_tap(input logic [2:0] sel);
        case (sel)
            3'd1:    return 5;
            3'd2:    return 9;
            3'd3:    return 14;
            3'd4:    return 3;
            3'd5:    return 18;
            3'd6:    return 28;
            default: return 6;
        endcase
    endfunction

    function automatic logic [MAX_LEN-1:0] len_mask(input logic [2:0] sel);
        logic [MAX_LEN-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (i < seq_len(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/prbs_mr_ctrl.sv
module prbs_mr_ctrl
    import prbs_mr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [2:0] sel_i,
    output logic [2:0] sel_q_o,
    output logic       load_o,
    output logic       shift_o,
    output logic       emit_ok_o
);

    ctrl_state_t st_q, st_d;
    logic [2:0]  sel_q;
    logic        adv_q;
    logic        sel_chg;

    assign sel_chg = (sel_i != sel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_SEED;
            sel_q <= 3'd0;
            adv_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_i;
            adv_q <= en_i & ~sel_chg;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SEED: begin
                if (sel_chg)   st_d = ST_SEED;
                else if (en_i) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (sel_chg)   st_d = ST_SEED;
            end
        endcase
    end

    always_comb begin
        sel_q_o   = sel_q;
        load_o    = sel_chg;
        shift_o   = en_i & ~sel_chg;
        emit_ok_o = (st_q == ST_RUN) & adv_q;
    end

endmodule

// File: rtl/prbs_mr_lfsr.sv
module prbs_mr_lfsr
    import prbs_mr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [2:0]         sel_i,
    output logic [MAX_LEN-1:0] state_o
);

    logic [MAX_LEN-1:0] state_q;
    logic               fb;

    always_comb begin
        fb = state_q[seq_tap(sel_i) - 1] ^ state_q[seq_len(sel_i) - 1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= '1;
        else if (load_i)  state_q <= '1;
        else if (shift_i) state_q <= {state_q[MAX_LEN-2:0], fb};
    end

    assign state_o = state_q;

endmodule

// File: rtl/prbs_mr_shaper.sv
module prbs_mr_shaper
    import prbs_mr_pkg::*;
(
    input  logic [HIST_W-1:0] hist_i,
    input  logic [2:0]        ratio_i,
    input  logic              spacing_i,
    output logic              bit_o
);

    logic [1:0] quarter;
    logic [1:0] eighth;

    for (genvar s = 0; s < 2; s++) begin : g_spacing
        localparam int SP = (s == 0) ? 1 : 3;
        assign quarter[s] = hist_i[0] & hist_i[SP];
        assign eighth[s]  = hist_i[0] & hist_i[SP] & hist_i[2*SP];
    end

    always_comb begin
        unique case (ratio_i)
            MR_QUARTER:      bit_o =  quarter[spacing_i];
            MR_EIGHTH:       bit_o =  eighth[spacing_i];
            MR_THREE_QTR:    bit_o = ~quarter[spacing_i];
            MR_SEVEN_EIGHTH: bit_o = ~eighth[spacing_i];
            default:         bit_o =  hist_i[0];
        endcase
    end

endmodule

// File: rtl/prbs_mr_gen.sv
module prbs_mr_gen
    import prbs_mr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [2:0] poly_sel_i,
    input  logic [2:0] ratio_sel_i,
    input  logic       spacing_i,
    output logic       bit_o,
    output logic       period_start_o
);

    logic [2:0]         sel_q;
    logic               load;
    logic               shift;
    logic               emit_ok;
    logic [MAX_LEN-1:0] state;
    logic [MAX_LEN-1:0] mask;
    logic               at_first;

    prbs_mr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .sel_i     (poly_sel_i),
        .sel_q_o   (sel_q),
        .load_o    (load),
        .shift_o   (shift),
        .emit_ok_o (emit_ok)
    );

    prbs_mr_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .sel_i   (sel_q),
        .state_o (state)
    );

    prbs_mr_shaper u_shape (
        .hist_i    (state[HIST_W-1:0]),
        .ratio_i   (ratio_sel_i),
        .spacing_i (spacing_i),
        .bit_o     (bit_o)
    );

    assign mask           = len_mask(sel_q);
    assign at_first       = ((state & mask) == (mask & ~{{(MAX_LEN-1){1'b0}}, 1'b1}));
    assign period_start_o = emit_ok & at_first;

    // R7
    lock_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state & mask) != '0);

    // R6
    reload_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poly_sel_i != sel_q) |=> ((state & len_mask(sel_q)) == len_mask(sel_q)) && !period_start_o);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && poly_sel_i == sel_q) |=> ($stable(state) && !period_start_o));

    // R4
    first_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> !state[0]);

    // R8
    thin_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ratio_sel_i == MR_QUARTER || ratio_sel_i == MR_EIGHTH) && bit_o) |-> state[0]);

    // R10
    dense_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ratio_sel_i == MR_THREE_QTR || ratio_sel_i == MR_SEVEN_EIGHTH) && !bit_o) |-> state[0]);

endmodule

// File: tb/tb_prbs_mr_gen.sv
module tb_prbs_mr_gen;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [2:0] poly_sel_i = 3'd0;
    logic [2:0] ratio_sel_i = 3'd0;
    logic       spacing_i = 1'b0;
    logic       bit_o;
    logic       period_start_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    int am [0:4095];
    int nn [0:6] = '{7, 9, 11, 15, 20, 23, 31};
    int tt [0:6] = '{6, 5, 9, 14, 3, 18, 28};

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_mr_gen dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (en_i),
        .poly_sel_i     (poly_sel_i),
        .ratio_sel_i    (ratio_sel_i),
        .spacing_i      (spacing_i),
        .bit_o          (bit_o),
        .period_start_o (period_start_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic void build(input int n, input int t, input int len);
        for (int k = 0; k < len; k++) begin
            am[k] = ((k >= t) ? am[k-t] : 1) ^ ((k >= n) ? am[k-n] : 1);
        end
    endfunction

    function automatic int getb(input int j);
        return (j < 0) ? 1 : am[j];
    endfunction

    function automatic int shaped(input int k, input int ratio, input int d);
        int q, e;
        q = getb(k) & getb(k-d);
        e = q & getb(k-2*d);
        case (ratio)
            1: return q;
            2: return e;
            3: return 1 - q;
            4: return 1 - e;
            default: return getb(k);
        endcase
    endfunction

    task automatic do_reset(input logic [2:0] sel, input logic [2:0] ratio, input logic sp);
        en_i = 1'b0;
        poly_sel_i = sel;
        ratio_sel_i = ratio;
        spacing_i = sp;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        // R1: values while in reset and just after
        @(negedge clk);
        check("R1 bit in reset", int'(bit_o), 1);
        check("R1 pulse in reset", int'(period_start_o), 0);
        do_reset(3'd0, 3'd0, 1'b0);
        check("R1 bit after reset", int'(bit_o), 1);
        check("R1 pulse after reset", int'(period_start_o), 0);

        // R2 / R4: plain sequence per polynomial
        for (int s = 0; s < 7; s++) begin
            int per, cyc;
            per = (nn[s] <= 11) ? ((1 << nn[s]) - 1) : 0;
            cyc = (per != 0) ? per + 3 : 300;
            build(nn[s], tt[s], cyc);
            do_reset(3'(s), 3'd0, 1'b0);
            en_i = 1'b1;
            for (int k = 0; k < cyc; k++) begin
                int exp_p;
                step();
                exp_p = (k == 0 || (per != 0 && (k % per) == 0)) ? 1 : 0;
                check($sformatf("R2 n=%0d bit %0d", nn[s], k), int'(bit_o), am[k]);
                check($sformatf("R4 n=%0d pulse %0d", nn[s], k), int'(period_start_o), exp_p);
            end
            en_i = 1'b0;
        end

        // R2: code 7 behaves as n=7
        build(7, 6, 40);
        do_reset(3'd7, 3'd0, 1'b0);
        en_i = 1'b1;
        for (int k = 0; k < 40; k++) begin
            step();
            check($sformatf("R2 code7 bit %0d", k), int'(bit_o), am[k]);
        end

        // R3: n=7 prefix, counts and runs from the outputs alone
        begin
            string pre;
            int ones, zeros, run, lastb, maxz, maxo;
            pre = "0000001000001100001010";
            do_reset(3'd0, 3'd0, 1'b0);
            en_i = 1'b1;
            ones = 0; zeros = 0; run = 0; lastb = -1; maxz = 0; maxo = 0;
            for (int k = 0; k < 127; k++) begin
                step();
                if (k < 22) check($sformatf("R3 prefix %0d", k), int'(bit_o), int'(pre[k] - "0"));
                if (bit_o) ones++; else zeros++;
                run = (int'(bit_o) == lastb) ? run + 1 : 1;
                lastb = int'(bit_o);
                if (bit_o && run > maxo) maxo = run;
                if (!bit_o && run > maxz) maxz = run;
            end
            check("R3 ones", ones, 64);
            check("R3 zeros", zeros, 63);
            check("R3 max zero run", maxz, 6);
            check("R3 max one run", maxo, 7);
        end

        // R8 / R9 / R10: all ratio and spacing pairs over one n=7 period
        build(7, 6, 140);
        for (int sp = 0; sp < 2; sp++) begin
            for (int r = 0; r < 8; r++) begin
                int ones, pat, h1, h2, d, expo;
                d = (sp == 0) ? 1 : 3;
                do_reset(3'd0, 3'(r), 1'(sp));
                en_i = 1'b1;
                ones = 0; pat = 0; h1 = 1; h2 = 1;
                for (int k = 0; k < 127; k++) begin
                    step();
                    check($sformatf("R8 ratio %0d d=%0d bit %0d", r, d, k),
                          int'(bit_o), shaped(k, r, d));
                    if (bit_o) ones++;
                    if (k >= 2 && h2 == 1 && h1 == 0 && bit_o) pat++;
                    h2 = h1;
                    h1 = int'(bit_o);
                end
                case (r)
                    1: expo = 32;
                    2: expo = 16;
                    3: expo = 95;
                    4: expo = 111;
                    default: expo = 64;
                endcase
                check($sformatf("R8 R10 ones ratio %0d d=%0d", r, d), ones, expo);
                if (r == 1) begin
                    check($sformatf("R9 101 present d=%0d", d), (pat > 0) ? 1 : 0, sp);
                end
            end
        end

        // R5: enable low holds the sequence
        build(9, 5, 60);
        do_reset(3'd1, 3'd0, 1'b0);
        en_i = 1'b1;
        for (int k = 0; k < 20; k++) step();
        check("R5 before hold", int'(bit_o), am[19]);
        en_i = 1'b0;
        for (int k = 0; k < 10; k++) begin
            step();
            check($sformatf("R5 hold bit %0d", k), int'(bit_o), am[19]);
            check($sformatf("R5 hold pulse %0d", k), int'(period_start_o), 0);
        end
        en_i = 1'b1;
        for (int k = 20; k < 30; k++) begin
            step();
            check($sformatf("R5 resume bit %0d", k), int'(bit_o), am[k]);
        end

        // R6: select change while running
        poly_sel_i = 3'd2;
        step();
        check("R6 reload bit", int'(bit_o), 1);
        check("R6 reload pulse", int'(period_start_o), 0);
        build(11, 9, 40);
        for (int k = 0; k < 30; k++) begin
            step();
            check($sformatf("R6 new bit %0d", k), int'(bit_o), am[k]);
            check($sformatf("R6 new pulse %0d", k), int'(period_start_o), (k == 0) ? 1 : 0);
        end

        // R6: select change with enable low
        en_i = 1'b0;
        poly_sel_i = 3'd0;
        step();
        check("R6 idle reload bit", int'(bit_o), 1);
        check("R6 idle reload pulse", int'(period_start_o), 0);
        en_i = 1'b1;
        step();
        check("R6 idle first bit", int'(bit_o), 0);
        check("R6 idle first pulse", int'(period_start_o), 1);
        en_i = 1'b0;

        summary();
    end

endmodule